// File: doc/BRIEF.md
# Cartridge Slot Select Decoder

This block sits on the memory side of an 8-bit computer with a Z80-style bus. Software writes an 8-bit control port. Three of its bits gate the cartridge slot logic: a master cartridge enable and two extra enables for the upper two slots. The memory-request strobe and the two top address lines then pick one of four 16 KB slot banks. For that bank the block drives an active-low chip-select to the cartridge connector.

The same port bits also govern the rest of the memory map. When the cartridge enable is low, the system ROM in the lower 32 KB is shut off at every address. When either upper slot is enabled, all system RAM is disabled over the full 64 KB. When any slot select is asserted, the expansion-bus data transceiver is turned off. The selects do not use any read/write signal.

All decode outputs are combinational from the port register and the bus inputs. A copy of them, registered one cycle later, is also provided for observation. The block has no data stream, so it has no valid/ready handshake and no back-pressure. Every pin is a plain control or status signal, sampled on each clock.

Top module: `cart_slot_decoder`

## Requirements
- R1: While reset is held, the port register reads 8'hFF. All slot selects, the ROM enable and the RAM disable are high (inactive), and the transceiver enable and its registered copy are high (enabled).
- R2: The port register loads `port_wdata` at a rising clock edge only when `port_wr` is high and `port_addr` equals PORT_ADDR (default 8'h0F). A write to any other address leaves the register unchanged.
- R3: `port_rdata` shows the register value while `port_rd` is high and `port_addr` equals PORT_ADDR. Otherwise it reads 8'h00.
- R4: A slot select can be low only when port bit 0 (cartridge enable, active low) is 0 and `mreq_n` is 0.
- R5: `bank` (A15:A14) chooses the slot: 0 drives `slot_sel_n[0]`, 1 drives `slot_sel_n[1]`, 2 drives `slot_sel_n[2]`, 3 drives `slot_sel_n[3]`.
- R6: `slot_sel_n[2]` also needs port bit 6 = 0, and `slot_sel_n[3]` also needs port bit 7 = 0.
- R7: When port bit 0 = 0, `rom_en_n` is 1 at every address. When port bit 0 = 1, `rom_en_n` is 0 exactly when `mreq_n` = 0 and `bank` is 0 or 1.
- R8: `ram_dis_n` is 0 exactly when port bit 0 = 0 and at least one of port bits 6 and 7 is 0. This holds whatever the address and whatever `mreq_n` is.
- R9: `xbus_oe` is 0 exactly when some slot select is low.
- R10: At most one slot select is low in any cycle.
- R11: Each `*_q` output equals its combinational counterpart from the previous clock cycle.
- R12: All decode outputs follow the port value and the bus inputs in the same cycle. When the port is written back to 8'hFF, every disable is gone in the cycle right after that write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_wr | input | 1 | Port write strobe |
| port_rd | input | 1 | Port read strobe |
| port_addr | input | 8 | I/O port address |
| port_wdata | input | 8 | Write data |
| port_rdata | output | 8 | Read data, 0 when not selected |
| mreq_n | input | 1 | Memory request, active low |
| bank | input | 2 | Address bits A15:A14 |
| slot_sel_n | output | 4 | Slot chip-selects, active low |
| rom_en_n | output | 1 | System ROM enable, active low |
| ram_dis_n | output | 1 | System RAM disable, active low |
| xbus_oe | output | 1 | Expansion transceiver enable, active high |
| slot_sel_q_n | output | 4 | Registered slot selects |
| rom_en_q_n | output | 1 | Registered ROM enable |
| ram_dis_q_n | output | 1 | Registered RAM disable |
| xbus_oe_q | output | 1 | Registered transceiver enable |

## Verification
The bench puts the cartridge bit low with the two upper-slot bits in each of their four patterns. In each pattern it walks all four banks with memory-request both high and low. A design that gated slot 3 with the wrong bit, or left out the memory-request qualifier, would then assert a select that should stay quiet. The bench also checks three global effects away from any matching address: the RAM disable with no memory request, and the ROM inhibit and transceiver cut in the lower banks. A decoder that limited these effects to the selected 16 KB window would fail there. Writes to other port addresses, followed by a readback, catch a decoder that matches too loosely.

// File: rtl/cart_pkg.sv
package cart_pkg;
  localparam int NSLOT  = 4;
  localparam int BANK_W = $clog2(NSLOT);

  typedef struct packed {
    logic [NSLOT-1:0] sel_n;
    logic             rom_en_n;
    logic             ram_dis_n;
    logic             xbus_oe;
  } mem_ctl_t;

  localparam mem_ctl_t CTL_IDLE = '{sel_n: '1, rom_en_n: 1'b1,
                                    ram_dis_n: 1'b1, xbus_oe: 1'b1};
endpackage

// File: rtl/cart_port_reg.sv
module cart_port_reg #(
  parameter int          DATA_W    = 8,
  parameter int          PADDR_W   = 8,
  parameter logic [7:0]  PORT_ADDR = 8'h0F,
  parameter logic [7:0]  RESET_VAL = 8'hFF
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [PADDR_W-1:0] addr,
  input  logic [DATA_W-1:0]  wdata,
  output logic [DATA_W-1:0]  rdata,
  output logic [DATA_W-1:0]  q
);
  logic hit;
  assign hit = (addr == PADDR_W'(PORT_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= DATA_W'(RESET_VAL);
    else if (wr && hit)  q <= wdata;
  end

  assign rdata = (rd && hit) ? q : '0;
endmodule

// File: rtl/cart_slot_decode.sv
module cart_slot_decode
  import cart_pkg::*;
(
  input  logic              cart_n,
  input  logic              up3_n,
  input  logic              up4_n,
  input  logic              mreq_n,
  input  logic [BANK_W-1:0] bank,
  output logic [NSLOT-1:0]  sel_n
);
  logic cycle_ok;
  assign cycle_ok = !cart_n && !mreq_n;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic gate;
    if (g == NSLOT - 2) begin : g_up3
      assign gate = !up3_n;
    end else if (g == NSLOT - 1) begin : g_up4
      assign gate = !up4_n;
    end else begin : g_low
      assign gate = 1'b1;
    end
    assign sel_n[g] = !(cycle_ok && gate && (bank == BANK_W'(g)));
  end
endmodule

// File: rtl/cart_region_ctl.sv
module cart_region_ctl
  import cart_pkg::*;
(
  input  logic              cart_n,
  input  logic              up3_n,
  input  logic              up4_n,
  input  logic              mreq_n,
  input  logic [BANK_W-1:0] bank,
  input  logic [NSLOT-1:0]  sel_n,
  output logic              rom_en_n,
  output logic              ram_dis_n,
  output logic              xbus_oe
);
  logic rom_window;
  assign rom_window = !bank[BANK_W-1];

  always_comb begin
    rom_en_n  = !(cart_n && !mreq_n && rom_window);
    ram_dis_n = !(!cart_n && (!up3_n || !up4_n));
    xbus_oe   = &sel_n;
  end
endmodule

// File: rtl/cart_slot_decoder.sv
module cart_slot_decoder
  import cart_pkg::*;
#(
  parameter int          DATA_W    = 8,
  parameter int          PADDR_W   = 8,
  parameter logic [7:0]  PORT_ADDR = 8'h0F,
  parameter int          CART_BIT  = 0,
  parameter int          UP3_BIT   = 6,
  parameter int          UP4_BIT   = 7
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               port_wr,
  input  logic               port_rd,
  input  logic [PADDR_W-1:0] port_addr,
  input  logic [DATA_W-1:0]  port_wdata,
  output logic [DATA_W-1:0]  port_rdata,
  input  logic               mreq_n,
  input  logic [BANK_W-1:0]  bank,
  output logic [NSLOT-1:0]   slot_sel_n,
  output logic               rom_en_n,
  output logic               ram_dis_n,
  output logic               xbus_oe,
  output logic [NSLOT-1:0]   slot_sel_q_n,
  output logic               rom_en_q_n,
  output logic               ram_dis_q_n,
  output logic               xbus_oe_q
);
  logic [DATA_W-1:0] port_q;
  logic cart_n, up3_n, up4_n;
  mem_ctl_t ctl_now, ctl_q;

  cart_port_reg #(
    .DATA_W(DATA_W), .PADDR_W(PADDR_W),
    .PORT_ADDR(PORT_ADDR), .RESET_VAL(8'hFF)
  ) u_port (
    .clk(clk), .rst_n(rst_n), .wr(port_wr), .rd(port_rd),
    .addr(port_addr), .wdata(port_wdata), .rdata(port_rdata), .q(port_q)
  );

  assign cart_n = port_q[CART_BIT];
  assign up3_n  = port_q[UP3_BIT];
  assign up4_n  = port_q[UP4_BIT];

  cart_slot_decode u_dec (
    .cart_n(cart_n), .up3_n(up3_n), .up4_n(up4_n),
    .mreq_n(mreq_n), .bank(bank), .sel_n(slot_sel_n)
  );

  cart_region_ctl u_reg (
    .cart_n(cart_n), .up3_n(up3_n), .up4_n(up4_n),
    .mreq_n(mreq_n), .bank(bank), .sel_n(slot_sel_n),
    .rom_en_n(rom_en_n), .ram_dis_n(ram_dis_n), .xbus_oe(xbus_oe)
  );

  assign ctl_now = '{sel_n: slot_sel_n, rom_en_n: rom_en_n,
                     ram_dis_n: ram_dis_n, xbus_oe: xbus_oe};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= CTL_IDLE;
    else        ctl_q <= ctl_now;
  end

  assign slot_sel_q_n = ctl_q.sel_n;
  assign rom_en_q_n   = ctl_q.rom_en_n;
  assign ram_dis_q_n  = ctl_q.ram_dis_n;
  assign xbus_oe_q    = ctl_q.xbus_oe;
endmodule

// File: rtl/cart_slot_decoder_chk.sv
module cart_slot_decoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       port_wr,
  input logic [7:0] port_addr,
  input logic [7:0] port_wdata,
  input logic [7:0] port_q,
  input logic       mreq_n,
  input logic [3:0] slot_sel_n,
  input logic       rom_en_n,
  input logic       ram_dis_n,
  input logic       xbus_oe,
  input logic [3:0] slot_sel_q_n,
  input logic       rom_en_q_n,
  input logic       ram_dis_q_n,
  input logic       xbus_oe_q
);
  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (port_wr && port_addr == 8'h0F) |=> port_q == $past(port_wdata));
  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(port_wr && port_addr == 8'h0F) |=> $stable(port_q));
  p_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (mreq_n || port_q[0]) |-> slot_sel_n == 4'hF);
  p_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (port_q[6] |-> slot_sel_n[2]) and (port_q[7] |-> slot_sel_n[3]));
  p_rom_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !port_q[0] |-> rom_en_n);
  p_ram_r8: assert property (@(posedge clk) disable iff (!rst_n)
    port_q[0] |-> ram_dis_n);
  p_xbus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (slot_sel_n != 4'hF) |-> !xbus_oe);
  p_onehot_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~slot_sel_n));
  p_pipe_r11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (slot_sel_q_n == $past(slot_sel_n)) && (rom_en_q_n == $past(rom_en_n))
          && (ram_dis_q_n == $past(ram_dis_n)) && (xbus_oe_q == $past(xbus_oe)));
endmodule

bind cart_slot_decoder cart_slot_decoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .port_wr(port_wr), .port_addr(port_addr),
  .port_wdata(port_wdata), .port_q(port_q), .mreq_n(mreq_n),
  .slot_sel_n(slot_sel_n), .rom_en_n(rom_en_n), .ram_dis_n(ram_dis_n),
  .xbus_oe(xbus_oe), .slot_sel_q_n(slot_sel_q_n), .rom_en_q_n(rom_en_q_n),
  .ram_dis_q_n(ram_dis_q_n), .xbus_oe_q(xbus_oe_q)
);

// File: tb/cart_slot_decoder_tb_top.sv
module cart_slot_decoder_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic port_wr = 1'b0, port_rd = 1'b0, mreq_n = 1'b1;
  logic [7:0] port_addr = 8'h00, port_wdata = 8'h00, port_rdata;
  logic [1:0] bank = 2'd0;
  logic [3:0] slot_sel_n, slot_sel_q_n;
  logic rom_en_n, ram_dis_n, xbus_oe, rom_en_q_n, ram_dis_q_n, xbus_oe_q;

  int checks = 0, errors = 0;
  logic [7:0] shadow = 8'hFF;
  logic [6:0] prev_exp = 7'b1111_111;

  always #10 clk = ~clk;

  cart_slot_decoder dut_i (.*);

  function automatic logic [6:0] model(logic [7:0] p, logic mq_n, logic [1:0] b);
    logic [3:0] s;
    logic on, rom, ram;
    on = !p[0] && !mq_n;
    s = 4'hF;
    if (on && (b < 2 || (b == 2 && !p[6]) || (b == 3 && !p[7]))) s[b] = 1'b0;
    rom = p[0] ? !(!mq_n && !b[1]) : 1'b1;
    ram = !(!p[0] && (!p[6] || !p[7]));
    return {s, rom, ram, &s};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(logic wr, logic rd, logic [7:0] a, logic [7:0] d,
                      logic mq, logic [1:0] b);
    logic [6:0] e;
    @(negedge clk);
    port_wr = wr; port_rd = rd; port_addr = a; port_wdata = d;
    mreq_n = mq; bank = b;
    #2;
    e = model(shadow, mq, b);
    chk("R4 R5 R6 select", 32'(slot_sel_n), 32'(e[6:3]));
    chk("R7 rom", 32'(rom_en_n), 32'(e[2]));
    chk("R8 ram", 32'(ram_dis_n), 32'(e[1]));
    chk("R9 xbus", 32'(xbus_oe), 32'(e[0]));
    chk("R10 onehot", 32'($countones(~slot_sel_n) <= 1), 32'd1);
    chk("R11 registered", 32'({slot_sel_q_n, rom_en_q_n, ram_dis_q_n, xbus_oe_q}),
        32'(prev_exp));
    chk("R3 rdata", 32'(port_rdata), 32'((rd && a == 8'h0F) ? shadow : 8'h00));
    prev_exp = e;
    if (wr && a == 8'h0F) shadow = d;
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] pats [4];
    void'($urandom(32'd4711));
    pats = '{8'hFE, 8'hBE, 8'h7E, 8'h3E};
    port_rd = 1'b1; port_addr = 8'h0F;
    repeat (3) @(negedge clk);
    #2;
    chk("R1 port reset", 32'(port_rdata), 32'hFF);
    chk("R1 outputs reset", 32'({slot_sel_n, rom_en_n, ram_dis_n, xbus_oe,
        slot_sel_q_n, rom_en_q_n, ram_dis_q_n, xbus_oe_q}), 32'h3FFF);
    port_rd = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    // R7 ROM decode with cartridge off
    for (int b = 0; b < 4; b++) step(0, 0, 8'h00, 8'h00, 1'b0, 2'(b));
    // R6 R8 every upper-enable pattern, all banks, mreq both ways
    foreach (pats[i]) begin
      step(1, 0, 8'h0F, pats[i], 1'b1, 2'd0);
      for (int b = 0; b < 4; b++) begin
        step(0, 0, 8'h00, 8'h00, 1'b0, 2'(b));
        step(0, 1, 8'h0F, 8'h00, 1'b1, 2'(b));
      end
    end
    // R2 writes elsewhere ignored
    step(1, 0, 8'h0E, 8'hFF, 1'b0, 2'd0);
    step(1, 0, 8'h8F, 8'hFF, 1'b0, 2'd1);
    step(0, 1, 8'h0F, 8'h00, 1'b0, 2'd2);
    chk("R2 ignored write", 32'(port_rdata), 32'h3E);
    // R12 restore takes effect on next cycle
    step(1, 0, 8'h0F, 8'hFF, 1'b0, 2'd3);
    step(0, 0, 8'h00, 8'h00, 1'b0, 2'd0);
    chk("R12 restored", 32'({slot_sel_n, rom_en_n, ram_dis_n, xbus_oe}), 32'b1111_011);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] a, d;
      a = ($urandom % 2) ? 8'h0F : 8'($urandom);
      d = 8'($urandom) & 8'b1111_1110 | 8'($urandom % 4 == 0);
      step(($urandom % 8) == 0, $urandom % 2, a, d, 1'($urandom), 2'($urandom));
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule